// File: doc/BRIEF.md
# Output Setpoint Transition Sequencer

This block drives a 6-bit DAC code for a switching regulator's output voltage. The code moves toward one of two stored setpoint codes. A hardware/software mode input decides which setpoint is the target and what starts a transition. In hardware mode, a select pin chooses between the two setpoints. A change of that pin, or a write to the setpoint register it currently selects, starts a transition. In software mode, setpoint 1 is always the target and nothing moves until a GO request is accepted. The GO flag then clears by itself.

A 3-bit slew code sets how the DAC code moves. Codes 0 to 6 step the code one LSB at a time, with a spacing of `STEP_BASE << slew` clocks between steps. Code 7 loads the target at once. A power-good flag drops when a transition toward a different code starts. It returns high a fixed number of clocks after the code lands on the target, with one delay for ramps and a longer one for jumps. A light-load (pulse-frequency) permission flag follows the mode of the accepted setpoint. It is forced low while an upward transition is in flight. A new target that arrives mid-ramp redirects the ramp from the present code.

Top module: `vout_setpoint_seq`

## Requirements
- R1: In hardware mode (`hw_mode`=1) with `sel_pin`=0, setpoint 0 is the target and `pfm_ok` is 1 once settled, whatever `mode1_pfm` is.
- R2: In hardware mode with `sel_pin`=1, setpoint 1 is the target and, once settled, `pfm_ok` equals `mode1_pfm` (1 allows light-load operation).
- R3: In software mode (`hw_mode`=0), setpoint 1 is the only target; `sel_pin` changes and setpoint writes start nothing.
- R4: In software mode a `go_set` pulse makes `go_bit` read 1 for exactly one cycle; at the edge that ends that cycle, the current setpoint 1 and slew code are accepted and `go_bit` returns to 0. `go_set` in hardware mode leaves `go_bit` at 0.
- R5: In hardware mode, a transition is accepted at the clock edge that sees `sel_pin` differ from its previous sampled value, or that sees the write strobe of the selected setpoint; the strobe of the unselected setpoint has no effect.
- R6: For slew code n in 0..6, `dac_code` moves by exactly one LSB per step toward the target, the first step `STEP_BASE << n` clocks after acceptance and the rest at that spacing.
- R7: Slew code 7 makes `dac_code` equal the target at the acceptance edge.
- R8: `pwr_ok` goes low at an acceptance edge whose target differs from `dac_code`, and rises `RAMP_SETTLE` clocks after the code reaches the target by stepping or `JUMP_SETTLE` clocks after a jump; `dac_code` never changes while `pwr_ok` is 1 unless a transition is accepted.
- R9: `pfm_ok` is 0 from acceptance of an upward target until `pwr_ok` rises; a downward transition does not force it low.
- R10: A target accepted mid-ramp continues stepping from the present `dac_code` without `pwr_ok` going high in between.
- R11: After reset `dac_code`=`RST_CODE` (0), `pwr_ok`=1, `pfm_ok`=1, `go_bit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_pin | input | 1 | Hardware setpoint select pin |
| hw_mode | input | 1 | 1 = pin-controlled, 0 = software GO control |
| setpt0 | input | 6 | Setpoint 0 code |
| setpt1 | input | 6 | Setpoint 1 code |
| wr_setpt0 | input | 1 | Write strobe of setpoint 0 |
| wr_setpt1 | input | 1 | Write strobe of setpoint 1 |
| mode1_pfm | input | 1 | Light-load permission for setpoint 1 |
| slew_code | input | 3 | Step rate select; 7 = immediate |
| go_set | input | 1 | Software GO request strobe |
| dac_code | output | 6 | DAC code driven to the regulator |
| pwr_ok | output | 1 | Output settled flag |
| pfm_ok | output | 1 | Light-load operation allowed |
| go_bit | output | 1 | Pending GO flag, self-clearing |

## Verification
A stale step timer shows up on `dac_code` as a step that comes early or late. It is visible no later than one step interval after acceptance, which is at most 128 clocks at default parameters. A wrong direction or target register also shows on `dac_code`, at the very next step. A corrupted settle counter or inhibit flag shows as a `pwr_ok` or `pfm_ok` edge in the wrong cycle, within `JUMP_SETTLE` clocks of landing. A bad trigger decode shows as a missed or spurious move on the first clock after the stimulus.

// File: rtl/sp_seq_pkg.sv
package sp_seq_pkg;

  // direction of a requested move relative to the present DAC code
  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_RISE = 2'd1,
    SP_FALL = 2'd2
  } sp_dir_e;

endpackage

// File: rtl/sp_target_sel.sv
module sp_target_sel #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_pin,
  input  logic              hw_mode,
  input  logic [CODE_W-1:0] setpt0,
  input  logic [CODE_W-1:0] setpt1,
  input  logic              wr_setpt0,
  input  logic              wr_setpt1,
  input  logic              mode1_pfm,
  input  logic              go_set,
  output logic [CODE_W-1:0] tgt_code,
  output logic              tgt_pfm,
  output logic              accept,
  output logic              go_bit
);

  logic pin_q, pin_d;
  logic go_q, go_d;
  logic use_sp1;
  logic wr_sel;

  always_comb begin
    use_sp1  = hw_mode ? sel_pin : 1'b1;
    tgt_code = use_sp1 ? setpt1 : setpt0;
    tgt_pfm  = use_sp1 ? mode1_pfm : 1'b1;
    wr_sel   = use_sp1 ? wr_setpt1 : wr_setpt0;
    if (hw_mode) begin
      accept = (sel_pin != pin_q) || wr_sel;
    end else begin
      accept = go_q;
    end
    pin_d = sel_pin;
    // GO is latched only in software mode and drops once consumed
    go_d  = (!hw_mode && !go_q) ? go_set : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      pin_q <= pin_d;
      go_q  <= go_d;
    end
  end

  assign go_bit = go_q;

endmodule

// File: rtl/sp_ramp.sv
module sp_ramp
  import sp_seq_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int SLEW_W    = 3,
  parameter int STEP_BASE = 2,
  parameter int RST_CODE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic [SLEW_W-1:0] slew_code,
  output logic [CODE_W-1:0] dac_code,
  output logic [CODE_W-1:0] tgt_q,
  output sp_dir_e           req_dir,
  output logic              jump_acc,
  output logic              at_target
);

  localparam int JUMP_SLEW = (1 << SLEW_W) - 1;
  localparam int MAX_IV    = STEP_BASE << (JUMP_SLEW - 1);
  localparam int SCNT_W    = $clog2(MAX_IV + 1);

  logic [CODE_W-1:0] dac_q, dac_d;
  logic [CODE_W-1:0] tgt_r, tgt_d;
  logic [SLEW_W-1:0] slew_q, slew_d;
  logic [SCNT_W-1:0] scnt_q, scnt_d;
  logic              upd_en;
  logic              step_due;

  function automatic logic [SCNT_W-1:0] iv_m1(input logic [SLEW_W-1:0] s);
    int iv;
    if (int'(s) == JUMP_SLEW) begin
      return '0;
    end
    iv = STEP_BASE << s;
    return SCNT_W'(iv - 1);
  endfunction

  always_comb begin
    at_target = (dac_q == tgt_r);
    jump_acc  = accept && (int'(slew_code) == JUMP_SLEW);
    if (tgt_code > dac_q) begin
      req_dir = SP_RISE;
    end else if (tgt_code < dac_q) begin
      req_dir = SP_FALL;
    end else begin
      req_dir = SP_HOLD;
    end
    step_due = !at_target && (scnt_q == '0);
    upd_en   = accept || !at_target;

    dac_d  = dac_q;
    tgt_d  = tgt_r;
    slew_d = slew_q;
    scnt_d = scnt_q;
    if (accept) begin
      tgt_d  = tgt_code;
      slew_d = slew_code;
      scnt_d = iv_m1(slew_code);
      if (jump_acc) begin
        dac_d = tgt_code;
      end
    end else if (!at_target) begin
      if (step_due) begin
        dac_d  = (tgt_r > dac_q) ? dac_q + 1'b1 : dac_q - 1'b1;
        scnt_d = iv_m1(slew_q);
      end else begin
        scnt_d = scnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q  <= CODE_W'(RST_CODE);
      tgt_r  <= CODE_W'(RST_CODE);
      slew_q <= '0;
      scnt_q <= '0;
    end else if (upd_en) begin
      dac_q  <= dac_d;
      tgt_r  <= tgt_d;
      slew_q <= slew_d;
      scnt_q <= scnt_d;
    end
  end

  assign dac_code = dac_q;
  assign tgt_q    = tgt_r;

endmodule

// File: rtl/sp_pgood.sv
module sp_pgood
  import sp_seq_pkg::*;
#(
  parameter int RAMP_SETTLE = 6,
  parameter int JUMP_SETTLE = 10
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept,
  input  sp_dir_e req_dir,
  input  logic    req_jump,
  input  logic    at_target,
  input  logic    tgt_pfm,
  output logic    pwr_ok,
  output logic    pfm_ok
);

  localparam int MAX_SET = (RAMP_SETTLE > JUMP_SETTLE) ? RAMP_SETTLE : JUMP_SETTLE;
  localparam int PCNT_W  = $clog2(MAX_SET + 1);

  logic              pok_q, pok_d;
  logic              up_q, up_d;
  logic              mode_q, mode_d;
  logic              jmp_q, jmp_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [PCNT_W-1:0] lim;
  logic              upd_en;

  always_comb begin
    lim    = jmp_q ? PCNT_W'(JUMP_SETTLE - 1) : PCNT_W'(RAMP_SETTLE - 1);
    upd_en = accept || (at_target && !pok_q);
    pok_d  = pok_q;
    up_d   = up_q;
    mode_d = mode_q;
    jmp_d  = jmp_q;
    pcnt_d = pcnt_q;
    if (accept) begin
      mode_d = tgt_pfm;
      jmp_d  = req_jump;
      pcnt_d = '0;
      if (req_dir != SP_HOLD) begin
        pok_d = 1'b0;
      end
      if (req_dir == SP_RISE) begin
        up_d = 1'b1;
      end else if (req_dir == SP_FALL) begin
        up_d = 1'b0;
      end
    end else if (at_target && !pok_q) begin
      if (pcnt_q == lim) begin
        pok_d = 1'b1;
        up_d  = 1'b0;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pok_q  <= 1'b1;
      up_q   <= 1'b0;
      mode_q <= 1'b1;
      jmp_q  <= 1'b0;
      pcnt_q <= '0;
    end else if (upd_en) begin
      pok_q  <= pok_d;
      up_q   <= up_d;
      mode_q <= mode_d;
      jmp_q  <= jmp_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign pwr_ok = pok_q;
  assign pfm_ok = mode_q & ~up_q;

endmodule

// File: rtl/vout_setpoint_seq.sv
module vout_setpoint_seq
  import sp_seq_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SLEW_W      = 3,
  parameter int STEP_BASE   = 2,
  parameter int RAMP_SETTLE = 6,
  parameter int JUMP_SETTLE = 10,
  parameter int RST_CODE    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_pin,
  input  logic              hw_mode,
  input  logic [CODE_W-1:0] setpt0,
  input  logic [CODE_W-1:0] setpt1,
  input  logic              wr_setpt0,
  input  logic              wr_setpt1,
  input  logic              mode1_pfm,
  input  logic [SLEW_W-1:0] slew_code,
  input  logic              go_set,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_ok,
  output logic              pfm_ok,
  output logic              go_bit
);

  logic              rsync1, arst_n;
  logic [CODE_W-1:0] tgt_code;
  logic [CODE_W-1:0] tgt_q;
  logic              tgt_pfm;
  logic              accept;
  logic              jump_acc;
  logic              at_target;
  sp_dir_e           req_dir;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync1 <= 1'b0;
      arst_n <= 1'b0;
    end else begin
      rsync1 <= 1'b1;
      arst_n <= rsync1;
    end
  end

  sp_target_sel #(.CODE_W(CODE_W)) u_sel (
    .clk      (clk),
    .rst_n    (arst_n),
    .sel_pin  (sel_pin),
    .hw_mode  (hw_mode),
    .setpt0   (setpt0),
    .setpt1   (setpt1),
    .wr_setpt0(wr_setpt0),
    .wr_setpt1(wr_setpt1),
    .mode1_pfm(mode1_pfm),
    .go_set   (go_set),
    .tgt_code (tgt_code),
    .tgt_pfm  (tgt_pfm),
    .accept   (accept),
    .go_bit   (go_bit)
  );

  sp_ramp #(
    .CODE_W   (CODE_W),
    .SLEW_W   (SLEW_W),
    .STEP_BASE(STEP_BASE),
    .RST_CODE (RST_CODE)
  ) u_ramp (
    .clk      (clk),
    .rst_n    (arst_n),
    .accept   (accept),
    .tgt_code (tgt_code),
    .slew_code(slew_code),
    .dac_code (dac_code),
    .tgt_q    (tgt_q),
    .req_dir  (req_dir),
    .jump_acc (jump_acc),
    .at_target(at_target)
  );

  sp_pgood #(
    .RAMP_SETTLE(RAMP_SETTLE),
    .JUMP_SETTLE(JUMP_SETTLE)
  ) u_pgood (
    .clk      (clk),
    .rst_n    (arst_n),
    .accept   (accept),
    .req_dir  (req_dir),
    .req_jump (jump_acc),
    .at_target(at_target),
    .tgt_pfm  (tgt_pfm),
    .pwr_ok   (pwr_ok),
    .pfm_ok   (pfm_ok)
  );

endmodule

// File: rtl/sp_seq_chk.sv
module sp_seq_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              arst_n,
  input logic [CODE_W-1:0] dac_code,
  input logic [CODE_W-1:0] tgt_q,
  input logic              pwr_ok,
  input logic              pfm_ok,
  input logic              go_bit,
  input logic              accept,
  input logic              jump_acc
);

  AST_ONE_LSB_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    !jump_acc |=> ($stable(dac_code) || (dac_code == $past(dac_code) + 1'b1) || (dac_code == $past(dac_code) - 1'b1))); // R6

  AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (!arst_n)
    jump_acc |=> (dac_code == tgt_q)); // R7

  AST_POK_LOW_WHILE_MOVING: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(dac_code) |-> !pwr_ok); // R8

  AST_IDLE_HOLDS_CODE: assert property (@(posedge clk) disable iff (!arst_n)
    (pwr_ok && !accept) |=> $stable(dac_code)); // R8

  AST_PFM_BLOCKED_RISING: assert property (@(posedge clk) disable iff (!arst_n)
    (tgt_q > dac_code) |-> !pfm_ok); // R9

  AST_GO_SELF_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
    go_bit |=> !go_bit); // R4

endmodule

bind vout_setpoint_seq sp_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .arst_n  (arst_n),
  .dac_code(dac_code),
  .tgt_q   (tgt_q),
  .pwr_ok  (pwr_ok),
  .pfm_ok  (pfm_ok),
  .go_bit  (go_bit),
  .accept  (accept),
  .jump_acc(jump_acc)
);

// File: tb/tb_vout_setpoint_seq.sv
module tb_vout_setpoint_seq;

  localparam int BASE = 2;
  localparam int RS   = 6;
  localparam int JS   = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, hw = 1'b1, wr0 = 1'b0, wr1 = 1'b0, mode1 = 1'b1, go = 1'b0;
  logic [5:0] sp0 = 6'd0, sp1 = 6'd0;
  logic [2:0] slew = 3'd0;
  logic [5:0] dac_code;
  logic       pwr_ok, pfm_ok, go_bit;

  int n_vec = 0, n_fail = 0, cyc = 0;
  string cur_req = "R11";

  // reference model state
  int m_dac = 0, m_tgt = 0, m_slew = 0, m_scnt = 0, m_pcnt = 0;
  bit m_pok = 1, m_up = 0, m_mode = 1, m_jump = 0, m_go = 0, m_pin = 0;
  bit mr1 = 0, mr2 = 0;

  always #5 clk = ~clk;

  vout_setpoint_seq dut (
    .clk(clk), .rst_n(rst_n), .sel_pin(pin), .hw_mode(hw),
    .setpt0(sp0), .setpt1(sp1), .wr_setpt0(wr0), .wr_setpt1(wr1),
    .mode1_pfm(mode1), .slew_code(slew), .go_set(go),
    .dac_code(dac_code), .pwr_ok(pwr_ok), .pfm_ok(pfm_ok), .go_bit(go_bit)
  );

  task automatic m_reset();
    m_dac = 0; m_tgt = 0; m_slew = 0; m_scnt = 0; m_pcnt = 0;
    m_pok = 1; m_up = 0; m_mode = 1; m_jump = 0; m_go = 0; m_pin = 0;
  endtask

  task automatic m_step();
    int tg;
    bit sel, md, acc, at;
    sel = hw ? pin : 1'b1;
    tg  = sel ? int'(sp1) : int'(sp0);
    md  = sel ? mode1 : 1'b1;
    acc = hw ? ((pin != m_pin) || (sel ? wr1 : wr0)) : m_go;
    at  = (m_dac == m_tgt);
    if (acc) begin
      if (tg != m_dac) m_pok = 0;
      if (tg > m_dac) m_up = 1;
      else if (tg < m_dac) m_up = 0;
      m_mode = md; m_jump = (slew == 3'd7); m_pcnt = 0;
      m_tgt = tg; m_slew = int'(slew);
      m_scnt = (slew == 3'd7) ? 0 : (BASE << slew) - 1;
      if (slew == 3'd7) m_dac = tg;
    end else if (!at) begin
      if (m_scnt == 0) begin
        m_dac  = (m_tgt > m_dac) ? m_dac + 1 : m_dac - 1;
        m_scnt = (BASE << m_slew) - 1;
      end else begin
        m_scnt = m_scnt - 1;
      end
    end else if (!m_pok) begin
      if (m_pcnt == (m_jump ? JS : RS) - 1) begin
        m_pok = 1; m_up = 0;
      end else begin
        m_pcnt = m_pcnt + 1;
      end
    end
    m_go  = hw ? 1'b0 : (m_go ? 1'b0 : go);
    m_pin = pin;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 = 0; mr2 = 0; m_reset();
    end else begin
      if (!mr2) m_reset(); else m_step();
      mr2 = mr1; mr1 = 1;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      if (int'(dac_code) != m_dac) begin
        n_fail++; $display("FAIL %s dac_code act=%0d exp=%0d t=%0t", cur_req, dac_code, m_dac, $time);
      end
      if (pwr_ok != m_pok) begin
        n_fail++; $display("FAIL %s pwr_ok act=%0d exp=%0d t=%0t", cur_req, pwr_ok, m_pok, $time);
      end
      if (pfm_ok != (m_mode & ~m_up)) begin
        n_fail++; $display("FAIL %s pfm_ok act=%0d exp=%0d t=%0t", cur_req, pfm_ok, m_mode & ~m_up, $time);
      end
      if (go_bit != m_go) begin
        n_fail++; $display("FAIL %s go_bit act=%0d exp=%0d t=%0t", cur_req, go_bit, m_go, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (m_pok && m_dac == m_tgt && pwr_ok) break;
    end
    tick(2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    cur_req = "R11";
    chk(dac_code == 6'd0, "R11", "reset dac_code", int'(dac_code), 0);
    chk(pwr_ok == 1'b1, "R11", "reset pwr_ok", int'(pwr_ok), 1);
    chk(pfm_ok == 1'b1, "R11", "reset pfm_ok", int'(pfm_ok), 1);
    chk(go_bit == 1'b0, "R11", "reset go_bit", int'(go_bit), 0);

    // R1 R6 R8: ramp up on setpoint 0 write, pin low
    cur_req = "R1 R6 R8";
    sp0 = 6'd10; slew = 3'd0; mode1 = 1'b0; wr0 = 1'b1;
    tick(1); wr0 = 1'b0;
    chk(pwr_ok == 1'b0, "R8", "pwr_ok after accept", int'(pwr_ok), 0);
    settle();
    chk(dac_code == 6'd10, "R6", "ramp end", int'(dac_code), 10);
    chk(pfm_ok == 1'b1, "R1", "pfm with setpoint 0", int'(pfm_ok), 1);

    // R5: unselected write ignored
    cur_req = "R5";
    sp1 = 6'd50; wr1 = 1'b1;
    tick(1); wr1 = 1'b0;
    tick(10);
    chk(dac_code == 6'd10 && pwr_ok, "R5", "unselected write", int'(dac_code), 10);

    // R2 R7 R8: pin high, jump up
    cur_req = "R2 R7 R8 R9";
    slew = 3'd7; mode1 = 1'b1; pin = 1'b1;
    tick(1);
    chk(dac_code == 6'd50, "R7", "jump lands", int'(dac_code), 50);
    chk(pfm_ok == 1'b0, "R9", "pfm inhibited rising", int'(pfm_ok), 0);
    settle();

    // R9 R6: downward ramp keeps pfm allowed
    cur_req = "R9 R6";
    slew = 3'd2; pin = 1'b0;
    tick(20);
    chk(pfm_ok == 1'b1, "R9", "pfm on fall", int'(pfm_ok), 1);
    settle();

    // R2: setpoint 1 mode bit clear
    cur_req = "R2 R9";
    mode1 = 1'b0; sp1 = 6'd14; slew = 3'd1; pin = 1'b1;
    settle();
    chk(pfm_ok == 1'b0, "R2", "pfm follows mode1", int'(pfm_ok), 0);

    // R10: redirect mid-ramp
    cur_req = "R10";
    sp0 = 6'd40; slew = 3'd0; pin = 1'b0;
    tick(20);
    sp0 = 6'd3; wr0 = 1'b1;
    tick(1); wr0 = 1'b0;
    chk(pwr_ok == 1'b0, "R10", "pwr_ok held low on redirect", int'(pwr_ok), 0);
    settle();
    chk(dac_code == 6'd3, "R10", "redirect end", int'(dac_code), 3);

    // R3 R4: software mode
    cur_req = "R3 R4";
    hw = 1'b0; sp1 = 6'd20; slew = 3'd3;
    tick(2);
    pin = 1'b1; tick(3); pin = 1'b0; wr1 = 1'b1; tick(1); wr1 = 1'b0; tick(5);
    chk(dac_code == 6'd3 && pwr_ok, "R3", "no move before GO", int'(dac_code), 3);
    go = 1'b1; tick(1); go = 1'b0;
    chk(go_bit == 1'b1, "R4", "go_bit set", int'(go_bit), 1);
    tick(1);
    chk(go_bit == 1'b0, "R4", "go_bit cleared", int'(go_bit), 0);
    settle();
    chk(dac_code == 6'd20, "R4", "sw target reached", int'(dac_code), 20);

    // R6: slowest ramp code
    cur_req = "R6";
    slew = 3'd6; sp1 = 6'd22;
    go = 1'b1; tick(1); go = 1'b0;
    settle();

    // R4: GO in hardware mode ignored
    cur_req = "R4";
    hw = 1'b1;
    tick(2);
    go = 1'b1; tick(1); go = 1'b0;
    chk(go_bit == 1'b0, "R4", "go ignored in hw mode", int'(go_bit), 0);
    tick(5);
    chk(dac_code == 6'd22, "R4", "no move from hw GO", int'(dac_code), 22);

    tick(5);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule